// File: doc/BRIEF.md
# Dispatch Serialization Controller

This block sits between the decode stage and the execution units of a simple in-order pipeline. It gates the dispatch handshake according to the synchronization class of each decoded instruction. It counts the instructions that have been issued but have not yet reached the point where they report exceptions. It also keeps a three-bit execution context: supervisor mode, address translation enable and memory protection enable.

A plain instruction is issued as soon as the block is ready. A barrier instruction stops issue, waits until the in-flight count is zero, and then passes through without touching the context. A context-changing instruction also waits for the count to reach zero. After that it loads the context it carries and pulses a switch strobe. The instruction itself and every younger instruction then issue under the new context.

Exception requests stop issue at once. The controller collects the highest-priority request up to the moment the pipeline has drained, then switches to that request's context. A context-changing instruction that was waiting is considered again only after the exception has been taken. Every issued instruction leaves with the context it runs under on `disp_ctx`.

Top module: `dispatch_serializer`

## Requirements
- R1: In the running state, with no exception pending and fewer than the maximum in flight, an instruction of class 2'b00 (plain) sees `in_ready` high. It is issued (`disp_fire`) and tagged with the current `ctx`.
- R2: Once an instruction of class 2'b01 (barrier) or 2'b10/2'b11 (context-changing) is presented, nothing is issued until every older instruction has reported completion. The synchronizing instruction itself is issued only when the in-flight count is zero.
- R3: A barrier instruction is issued after the drain without any pulse on `ctx_switch` and without any change to `ctx`.
- R4: A context-changing instruction causes exactly one single-cycle `ctx_switch` pulse. `ctx` takes the instruction's `in_new_ctx` in the next cycle. Older instructions carry the old tag, while the instruction and younger ones carry the new tag. `ctx` changes only in the cycle after a pulse.
- R5: `in_ready` is low in any cycle in which `exc_req` is high. After the in-flight instructions have drained, `ctx` becomes that request's `exc_ctx`, with one `ctx_switch` pulse.
- R6: Among exception requests collected before the switch, the numerically largest `exc_prio` wins. On equal priority the earlier request is kept.
- R7: An exception raised in the last cycle before a context-changing instruction would switch preempts it. The exception's context is loaded first, and the instruction then goes through its own drain and switch.
- R8: `in_ready` is low while the number of instructions in flight equals 2**CNT_W-1.
- R9: After reset `ctx` is RST_CTX (default 3'b001: bit 0 supervisor, bit 1 translation, bit 2 protection), `ctx_switch` is low, and `in_ready` is high for a plain instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded instruction present |
| in_class | input | 2 | 00 plain, 01 barrier, 1x context-changing |
| in_new_ctx | input | 3 | Context set up by a context-changing instruction |
| in_ready | output | 1 | Instruction may be issued this cycle |
| disp_fire | output | 1 | Instruction issued this cycle |
| disp_ctx | output | 3 | Context tag of the issued instruction |
| cmpl_valid | input | 1 | One in-flight instruction reached its exception-reporting point |
| exc_req | input | 1 | Exception request |
| exc_prio | input | PRIO_W | Priority of the request, larger wins |
| exc_ctx | input | 3 | Context the exception handler runs under |
| ctx | output | 3 | Current context |
| ctx_switch | output | 1 | One-cycle strobe on a context load |

## Verification
The hardest case to reach is an exception that appears in the single cycle after the drain completes and before a context-changing instruction commits its switch. The bench reaches it with an empty pipeline, where the state sequence is fixed. It presents the instruction and counts two clock edges, then raises the request for exactly that cycle. It then checks that the exception's context is loaded first and the instruction's context second. A second scenario stacks requests of rising, falling and equal priority on a draining pipeline, which exercises the priority merge.

// File: rtl/dispatch_serializer.sv
module dispatch_serializer #(
  parameter int CNT_W = 3,
  parameter int PRIO_W = 2,
  parameter logic [2:0] RST_CTX = 3'b001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        in_class,
  input  logic [2:0]        in_new_ctx,
  output logic              in_ready,
  output logic              disp_fire,
  output logic [2:0]        disp_ctx,
  input  logic              cmpl_valid,
  input  logic              exc_req,
  input  logic [PRIO_W-1:0] exc_prio,
  input  logic [2:0]        exc_ctx,
  output logic [2:0]        ctx,
  output logic              ctx_switch
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  typedef enum logic [1:0] {RUN, DRAIN, WAIT_EXC, SWITCH} st_t;
  st_t st;

  logic [CNT_W-1:0]  cnt;
  logic              granted;
  logic              pend_v;
  logic [PRIO_W-1:0] pend_prio;
  logic [2:0]        pend_ctx;
  logic [2:0]        sw_ctx;
  logic              sw_exc;

  wire is_sync  = in_class != 2'b00;
  wire is_ctx   = in_class[1];
  wire take_req = exc_req && (!pend_v || exc_prio > pend_prio);
  wire any_exc  = exc_req || pend_v;
  wire [2:0] best_ctx = take_req ? exc_ctx : pend_ctx;

  assign in_ready   = (st == RUN) && !any_exc && (cnt != CNT_MAX) && (!is_sync || granted);
  assign disp_fire  = in_valid && in_ready;
  assign disp_ctx   = ctx;
  assign ctx_switch = (st == SWITCH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CNT_W'(disp_fire) - CNT_W'(cmpl_valid);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_prio <= '0;
      pend_ctx  <= '0;
    end else if (st == SWITCH) begin
      pend_v    <= exc_req;
      pend_prio <= exc_prio;
      pend_ctx  <= exc_ctx;
    end else if (take_req) begin
      pend_v    <= 1'b1;
      pend_prio <= exc_prio;
      pend_ctx  <= exc_ctx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= RUN;
      granted <= 1'b0;
      ctx     <= RST_CTX;
      sw_ctx  <= '0;
      sw_exc  <= 1'b0;
    end else begin
      case (st)
        RUN: begin
          if (disp_fire && is_sync) granted <= 1'b0;
          if (any_exc || (in_valid && is_sync && !granted)) st <= DRAIN;
        end
        DRAIN: if (cnt == '0) st <= WAIT_EXC;
        WAIT_EXC: begin
          if (any_exc) begin
            sw_ctx <= best_ctx;
            sw_exc <= 1'b1;
            st     <= SWITCH;
          end else if (in_valid && is_ctx) begin
            sw_ctx <= in_new_ctx;
            sw_exc <= 1'b0;
            st     <= SWITCH;
          end else begin
            granted <= in_valid && is_sync;
            st      <= RUN;
          end
        end
        default: begin
          ctx     <= sw_ctx;
          granted <= !sw_exc;
          st      <= RUN;
        end
      endcase
    end
  end

  // R2
  sync_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_fire && is_sync |-> cnt == '0);
  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_fire |-> cnt != CNT_MAX);
  // R4
  switch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_switch |=> !ctx_switch);
  // R4
  ctx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctx_switch |=> $stable(ctx));
  // R5
  exc_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> !disp_fire);
  // R2
  cmpl_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_valid |-> cnt != '0);
endmodule

// File: tb/dispatch_serializer_bench.sv
module dispatch_serializer_bench;
  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0;
  logic [1:0] in_class = 0;
  logic [2:0] in_new_ctx = 0;
  logic in_ready, disp_fire;
  logic [2:0] disp_ctx;
  logic cmpl_valid = 0;
  logic exc_req = 0;
  logic [1:0] exc_prio = 0;
  logic [2:0] exc_ctx = 0;
  logic [2:0] ctx;
  logic ctx_switch;

  int errors = 0, checks = 0;
  int bcnt = 0, sw_cnt = 0;
  logic [2:0] exp_ctx = 3'b001;

  always #5 clk = ~clk;

  dispatch_serializer u_dispatch_serializer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
    .in_new_ctx(in_new_ctx), .in_ready(in_ready), .disp_fire(disp_fire),
    .disp_ctx(disp_ctx), .cmpl_valid(cmpl_valid), .exc_req(exc_req),
    .exc_prio(exc_prio), .exc_ctx(exc_ctx), .ctx(ctx), .ctx_switch(ctx_switch));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    #1;
    if (in_valid && in_ready) begin
      if (in_class != 0) chk(bcnt == 0, "R2 sync issued undrained", bcnt, 0);
      chk(disp_ctx == exp_ctx, "R4 dispatch tag", disp_ctx, exp_ctx);
      bcnt++;
    end
    if (cmpl_valid) bcnt--;
    if (ctx_switch) sw_cnt++;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drain_all();
    in_valid = 0;
    while (bcnt > 0) begin cmpl_valid = 1; tick(); end
    cmpl_valid = 0;
    repeat (2) tick();
  endtask

  task automatic issue_plain(input int n);
    in_valid = 1; in_class = 2'b00;
    for (int i = 0; i < n; i++) begin
      #1 chk(in_ready, "R1 plain ready", in_ready, 1);
      tick();
    end
    in_valid = 0;
  endtask

  task automatic wait_ready(output bit seen);
    seen = 0;
    for (int i = 0; i < 12 && !seen; i++) begin
      #1 if (in_ready) seen = 1; else tick();
    end
  endtask

  task automatic test_reset();
    #1;
    chk(ctx == 3'b001, "R9 reset ctx", ctx, 1);
    chk(!ctx_switch, "R9 reset pulse", ctx_switch, 0);
    chk(in_ready, "R9 reset ready", in_ready, 1);
  endtask

  task automatic test_plain();
    issue_plain(3);
    chk(bcnt == 3, "R1 issued count", bcnt, 3);
    drain_all();
  endtask

  task automatic test_barrier();
    bit seen; int sw0;
    sw0 = sw_cnt;
    issue_plain(2);
    in_valid = 1; in_class = 2'b01;
    repeat (3) begin #1 chk(!in_ready, "R2 stall while busy", in_ready, 0); tick(); end
    cmpl_valid = 1;
    repeat (2) begin #1 chk(!in_ready, "R2 stall during drain", in_ready, 0); tick(); end
    cmpl_valid = 0;
    wait_ready(seen);
    chk(seen, "R2 barrier issued after drain", seen, 1);
    tick();
    in_valid = 0;
    tick();
    chk(sw_cnt == sw0, "R3 no switch pulse", sw_cnt - sw0, 0);
    chk(ctx == exp_ctx, "R3 ctx unchanged", ctx, exp_ctx);
    drain_all();
  endtask

  task automatic test_ctxsync();
    bit seen; int sw0;
    sw0 = sw_cnt;
    issue_plain(1);
    in_valid = 1; in_class = 2'b10; in_new_ctx = 3'b110;
    exp_ctx = 3'b110;
    tick();
    cmpl_valid = 1; tick(); cmpl_valid = 0;
    wait_ready(seen);
    chk(seen, "R4 ctx op issued", seen, 1);
    chk(disp_ctx == 3'b110, "R4 op tag new", disp_ctx, 6);
    tick();
    issue_plain(1);
    chk(sw_cnt - sw0 == 1, "R4 single pulse", sw_cnt - sw0, 1);
    chk(ctx == 3'b110, "R4 ctx loaded", ctx, 6);
    drain_all();
  endtask

  task automatic test_exc();
    bit seen; int sw0;
    sw0 = sw_cnt;
    issue_plain(1);
    in_valid = 1; in_class = 2'b00;
    exc_req = 1; exc_prio = 1; exc_ctx = 3'b011;
    #1 chk(!in_ready, "R5 blocked by exception", in_ready, 0);
    tick();
    exc_req = 0;
    repeat (3) tick();
    chk(ctx == 3'b110 && !in_ready, "R5 no switch before drain", ctx, 6);
    exp_ctx = 3'b011;
    cmpl_valid = 1; tick(); cmpl_valid = 0;
    wait_ready(seen);
    chk(seen && ctx == 3'b011, "R5 exception ctx", ctx, 3);
    chk(sw_cnt - sw0 == 1, "R5 one pulse", sw_cnt - sw0, 1);
    drain_all();
  endtask

  task automatic test_prio();
    bit seen; int sw0;
    sw0 = sw_cnt;
    issue_plain(1);
    in_valid = 1; in_class = 2'b10; in_new_ctx = 3'b100;
    exp_ctx = 3'b100;
    exc_req = 1;
    exc_prio = 1; exc_ctx = 3'b101; tick();
    exc_prio = 3; exc_ctx = 3'b111; tick();
    exc_prio = 2; exc_ctx = 3'b010; tick();
    exc_prio = 3; exc_ctx = 3'b000; tick();
    exc_req = 0;
    cmpl_valid = 1; tick(); cmpl_valid = 0;
    for (int i = 0; i < 8 && sw_cnt == sw0; i++) tick();
    chk(ctx == 3'b111, "R6 highest priority wins", ctx, 7);
    wait_ready(seen);
    chk(seen && disp_ctx == 3'b100, "R6 op after exception", disp_ctx, 4);
    tick();
    in_valid = 0;
    chk(sw_cnt - sw0 == 2, "R6 two switches", sw_cnt - sw0, 2);
    drain_all();
  endtask

  task automatic test_late_exc();
    bit seen;
    in_valid = 1; in_class = 2'b10; in_new_ctx = 3'b011;
    exp_ctx = 3'b011;
    tick();
    tick();
    exc_req = 1; exc_prio = 0; exc_ctx = 3'b110;
    tick();
    exc_req = 0;
    #1 chk(ctx_switch, "R7 switch for late exception", ctx_switch, 1);
    tick();
    chk(ctx == 3'b110, "R7 exception ctx first", ctx, 6);
    wait_ready(seen);
    chk(seen && disp_ctx == 3'b011, "R7 op ctx second", disp_ctx, 3);
    tick();
    in_valid = 0;
    drain_all();
  endtask

  task automatic test_full();
    issue_plain(7);
    in_valid = 1; in_class = 2'b00;
    #1 chk(!in_ready, "R8 saturated", in_ready, 0);
    tick();
    drain_all();
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    test_reset();
    test_plain();
    test_barrier();
    test_ctxsync();
    test_exc();
    test_prio();
    test_late_exc();
    test_full();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule